// File: doc/BRIEF.md
# Palette Memory Access Port

This block gives a host processor byte-wide access to a colour table of 256 entries. Each entry is a 15-bit colour: five bits each of red, green and blue, packed as a low byte and a 7-bit high byte whose top bit is always zero. The host first loads a colour index, which the block turns into a 9-bit byte address. It then streams bytes through a single data strobe. A byte written at an even address is only held in a latch. The following odd-address byte commits both halves of the colour in the same cycle, so a colour is never left half updated. Reads use the same byte address and step it forward in the same way.

The block watches the beam position that a video timing generator supplies, together with a display-off flag and an overscan select. While the beam is inside the active drawing window, any host access would collide with the renderer's own palette fetches. During that window, commits are redirected to the last byte of the table, and reads return that byte instead of the addressed one. The value read is presented on an 8-bit bus register. On high-byte reads, that register keeps its own top bit from the previous value.

Top module: `palette_port`

## Requirements
- R1: A pulse on `addr_wr` loads the byte address with `{wdata, 1'b0}`, so the next data access starts at the low byte of colour `wdata`.
- R2: A data write at an even byte address (bit 0 = 0) only loads the latch; no table byte changes.
- R3: A data write at an odd byte address stores the latched byte as the colour's low byte and `wdata[6:0]` as its high byte, in the same cycle.
- R4: The byte address advances by one after every data write and every data read, and wraps from 511 to 0.
- R5: A data read at an even address loads the whole stored low byte onto `rdata`, visible in the cycle after the strobe.
- R6: A data read at an odd address loads the stored 7-bit high byte into `rdata[6:0]` and leaves `rdata[7]` at its previous value.
- R7: Inside the active window, an odd-address commit writes only `wdata[6:0]` into the high byte of colour 255 (byte 0x1FF), and the addressed colour stays unchanged.
- R8: Inside the active window, every data read returns the high byte of colour 255 with bit 7 clear. The even/odd merge of R5/R6 applies, and the address still advances.
- R9: The active window is: `display_off` low, `vcount` below 225 (below 240 when `overscan` is high), and `hcount` from 72 up to and including 1095. Outside it, accesses reach the addressed byte.
- R10: The latch keeps its value across reads and address loads; only an even-address write replaces it.
- R11: Reset clears the byte address, the latch and `rdata` to zero.
- R12: When strobes coincide, `addr_wr` wins over `data_wr`, and `data_wr` wins over `data_rd`. The losing strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load colour index from `wdata` |
| data_wr | input | 1 | Write one byte from `wdata` |
| data_rd | input | 1 | Read one byte into `rdata` |
| wdata | input | 8 | Host write data / colour index |
| rdata | output | 8 | Read bus register |
| vcount | input | 9 | Current beam line |
| hcount | input | 11 | Current beam dot |
| display_off | input | 1 | Display forced off; disables redirection |
| overscan | input | 1 | Selects the taller visible area |

## Verification
Colour pairs are written and read back with the high byte's top bit set and clear, and with the previous bus value's top bit set and clear. This separates correct masking and bit-7 retention from a plain byte copy. Lone even writes, reads placed between a low and a high write, coinciding strobes and a read run past index 255 show that the latch, the strobe priority and the address wrap behave independently. Accesses are then repeated with the beam placed on each edge of the active window, with and without overscan and with the display off. Whether the redirected entry or the addressed entry answers shows where each boundary lies.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam int unsigned PAL_IDX_W  = 8;
    localparam int unsigned PAL_ADDR_W = PAL_IDX_W + 1;
    localparam int unsigned PAL_BYTE_W = 8;
    localparam int unsigned PAL_HI_W   = PAL_BYTE_W - 1;

    typedef struct packed {
        logic [PAL_ADDR_W-1:0] addr;
        logic [PAL_BYTE_W-1:0] latch;
        logic [PAL_BYTE_W-1:0] bus;
    } port_state_t;

    typedef struct packed {
        logic                 lo_we;
        logic                 hi_we;
        logic [PAL_IDX_W-1:0] idx;
        logic [PAL_BYTE_W-1:0] lo_din;
        logic [PAL_HI_W-1:0]  hi_din;
    } ram_wr_t;

endpackage

// File: rtl/palette_window.sv
module palette_window #(
    parameter int unsigned VW     = 9,
    parameter int unsigned HW     = 11,
    parameter int unsigned V_STD  = 225,
    parameter int unsigned V_OVR  = 240,
    parameter int unsigned H_LO   = 72,
    parameter int unsigned H_HI   = 1096
) (
    input  logic [VW-1:0] vcount,
    input  logic [HW-1:0] hcount,
    input  logic          display_off,
    input  logic          overscan,
    output logic          active
);
    logic [VW-1:0] line_limit;
    logic          in_lines;
    logic          in_dots;

    always_comb begin
        line_limit = overscan ? VW'(V_OVR) : VW'(V_STD);
        in_lines   = (vcount < line_limit);
        in_dots    = (hcount >= HW'(H_LO)) && (hcount < HW'(H_HI));
        active     = !display_off && in_lines && in_dots;
    end
endmodule

// File: rtl/palette_ram.sv
module palette_ram
    import palette_pkg::*;
(
    input  logic                   clk,
    input  ram_wr_t                wr,
    input  logic [PAL_ADDR_W-1:0]  rd_addr,
    output logic [PAL_BYTE_W-1:0]  rd_byte
);
    localparam int unsigned ENTRIES = 1 << PAL_IDX_W;

    logic [PAL_BYTE_W-1:0] lo_mem [ENTRIES];
    logic [PAL_HI_W-1:0]   hi_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr.lo_we) lo_mem[wr.idx] <= wr.lo_din;
        if (wr.hi_we) hi_mem[wr.idx] <= wr.hi_din;
    end

    always_comb begin
        if (rd_addr[0]) rd_byte = {1'b0, hi_mem[rd_addr[PAL_ADDR_W-1:1]]};
        else            rd_byte = lo_mem[rd_addr[PAL_ADDR_W-1:1]];
    end
endmodule

// File: rtl/palette_port.sv
module palette_port
    import palette_pkg::*;
#(
    parameter int unsigned VW     = 9,
    parameter int unsigned HW     = 11,
    parameter int unsigned V_STD  = 225,
    parameter int unsigned V_OVR  = 240,
    parameter int unsigned H_LO   = 72,
    parameter int unsigned H_HI   = 1096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [VW-1:0] vcount,
    input  logic [HW-1:0] hcount,
    input  logic          display_off,
    input  logic          overscan
);
    localparam logic [PAL_ADDR_W-1:0] TOP_ADDR = '1;
    localparam logic [PAL_IDX_W-1:0]  TOP_IDX  = '1;

    port_state_t st_d, st_q;
    ram_wr_t     wr_d;
    logic        win_active;
    logic [PAL_ADDR_W-1:0] rd_addr;
    logic [PAL_BYTE_W-1:0] rd_byte;

    palette_window #(
        .VW(VW), .HW(HW), .V_STD(V_STD), .V_OVR(V_OVR), .H_LO(H_LO), .H_HI(H_HI)
    ) win_i (
        .vcount(vcount), .hcount(hcount), .display_off(display_off),
        .overscan(overscan), .active(win_active)
    );

    palette_ram ram_i (
        .clk(clk), .wr(wr_d), .rd_addr(rd_addr), .rd_byte(rd_byte)
    );

    assign rd_addr = win_active ? TOP_ADDR : st_q.addr;

    always_comb begin
        st_d = st_q;
        wr_d = '0;
        wr_d.idx = st_q.addr[PAL_ADDR_W-1:1];
        if (addr_wr) begin
            st_d.addr = {wdata, 1'b0};
        end else if (data_wr) begin
            st_d.addr = st_q.addr + 1'b1;
            if (!st_q.addr[0]) begin
                st_d.latch = wdata;
            end else if (win_active) begin
                wr_d.hi_we  = 1'b1;
                wr_d.idx    = TOP_IDX;
                wr_d.hi_din = wdata[PAL_HI_W-1:0];
            end else begin
                wr_d.lo_we  = 1'b1;
                wr_d.hi_we  = 1'b1;
                wr_d.lo_din = st_q.latch;
                wr_d.hi_din = wdata[PAL_HI_W-1:0];
            end
        end else if (data_rd) begin
            st_d.addr = st_q.addr + 1'b1;
            if (!st_q.addr[0]) st_d.bus = win_active ? {1'b0, rd_byte[6:0]} : rd_byte;
            else               st_d.bus = {st_q.bus[7], rd_byte[6:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.bus;

    p_addr_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> st_q.addr == {$past(wdata), 1'b0});

    p_even_latch_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && !st_q.addr[0]) |-> (!wr_d.lo_we && !wr_d.hi_we));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_wr && (data_wr || data_rd)) |=> st_q.addr == $past(st_q.addr) + 1'b1);

    p_bit7_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !data_wr && !addr_wr && st_q.addr[0]) |=> rdata[7] == $past(rdata[7]));

    p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && st_q.addr[0] && win_active)
            |-> (wr_d.hi_we && !wr_d.lo_we && wr_d.idx == TOP_IDX));

    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && !addr_wr && !st_q.addr[0]) |=> $stable(st_q.latch));

    p_wr_blocks_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr || addr_wr) |=> $stable(rdata));
endmodule

// File: tb/palette_port_tb_top.sv
module palette_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_wr = 0, data_wr = 0, data_rd = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [8:0] vcount = 9'd300;
    logic [10:0] hcount = '0;
    logic display_off = 0, overscan = 0;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    palette_port dut_i (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .vcount(vcount),
        .hcount(hcount), .display_off(display_off), .overscan(overscan)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic strobe(input logic a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        addr_wr = a; data_wr = w; data_rd = r; wdata = d;
        @(negedge clk);
        addr_wr = 0; data_wr = 0; data_rd = 0;
    endtask

    task automatic set_idx(input logic [7:0] i); strobe(1, 0, 0, i); endtask
    task automatic wr(input logic [7:0] d);      strobe(0, 1, 0, d); endtask
    task automatic rd(input logic [7:0] exp, input string tag);
        strobe(0, 0, 1, 8'h00);
        check(rdata, exp, tag);
    endtask
    task automatic beam(input int v, input int h, input logic os, input logic off);
        vcount = 9'(v); hcount = 11'(h); overscan = os; display_off = off;
    endtask

    task automatic t_reset;
        check(rdata, 8'h00, "R11 rdata after reset");
        strobe(0, 0, 1, 8'h00);
        wr(8'h33);
        set_idx(8'd0);
        rd(8'h00, "R11 latch cleared, commit at index 0");
        rd(8'h33, "R11 high byte");
    endtask

    task automatic t_pairs;
        set_idx(8'd0); wr(8'h3C); wr(8'h81);
        set_idx(8'd0);
        rd(8'h3C, "R3 low byte committed");
        rd(8'h01, "R3 high byte bit7 masked");
        set_idx(8'd5); wr(8'hA5); wr(8'hFF);
        set_idx(8'd5);
        rd(8'hA5, "R5 even read full byte");
        rd(8'hFF, "R6 bit7 kept set from bus");
        set_idx(8'd6); wr(8'h12); wr(8'h34);
        set_idx(8'd6);
        rd(8'h12, "R1 index load");
        rd(8'h34, "R6 bit7 kept clear from bus");
    endtask

    task automatic t_even_only;
        set_idx(8'd9); wr(8'h01); wr(8'h02);
        set_idx(8'd9); wr(8'hEE);
        set_idx(8'd9);
        rd(8'h01, "R2 lone even write stores nothing");
        rd(8'h02, "R2 high byte untouched");
    endtask

    task automatic t_latch_hold;
        set_idx(8'd10); wr(8'h77);
        set_idx(8'd9);
        rd(8'h01, "R10 read between halves");
        wr(8'h44);
        set_idx(8'd9);
        rd(8'h77, "R10 latch survived read and address load");
        rd(8'h44, "R10 high byte");
    endtask

    task automatic t_wrap;
        set_idx(8'd255); wr(8'h80); wr(8'h7A);
        set_idx(8'd255);
        rd(8'h80, "R5 index 255 low");
        rd(8'hFA, "R6 index 255 high with bus bit7");
        rd(8'h3C, "R4 wrap 511 to 0");
    endtask

    task automatic t_priority;
        set_idx(8'd13); wr(8'h5A); wr(8'h01);
        set_idx(8'd12); wr(8'hAB); wr(8'h0C);
        strobe(1, 1, 0, 8'h0C);
        rd(8'hAB, "R12 address load beats data write");
        strobe(0, 1, 1, 8'h05);
        check(rdata, 8'hAB, "R12 data write beats read");
        rd(8'h5A, "R12 single step after combined strobe");
        set_idx(8'd12);
        rd(8'hAB, "R12 commit low");
        rd(8'h85, "R12 commit high");
    endtask

    task automatic t_window;
        set_idx(8'd3); wr(8'h55); wr(8'h66);
        beam(10, 100, 0, 0);
        set_idx(8'd3); wr(8'h11); wr(8'h92);
        beam(300, 0, 0, 0);
        set_idx(8'd3);
        rd(8'h55, "R7 addressed low unchanged");
        rd(8'h66, "R7 addressed high unchanged");
        set_idx(8'd255);
        rd(8'h80, "R7 index 255 low unchanged");
        rd(8'h92, "R7 redirected high byte");
        beam(10, 100, 0, 0);
        set_idx(8'd3);
        rd(8'h12, "R8 even read redirected");
        rd(8'h12, "R8 odd read redirected");
        beam(300, 0, 0, 0);
    endtask

    task automatic probe(input int v, input int h, input logic os, input logic off,
                         input logic [7:0] exp, input string tag);
        beam(v, h, os, off);
        set_idx(8'd3);
        rd(exp, tag);
    endtask

    task automatic t_bounds;
        probe(224, 72,   0, 0, 8'h12, "R9 last line first dot inside");
        probe(225, 100,  0, 0, 8'h55, "R9 line 225 outside");
        probe(100, 71,   0, 0, 8'h55, "R9 dot 71 outside");
        probe(100, 1095, 0, 0, 8'h12, "R9 dot 1095 inside");
        probe(100, 1096, 0, 0, 8'h55, "R9 dot 1096 outside");
        probe(239, 100,  1, 0, 8'h12, "R9 overscan line 239 inside");
        probe(240, 100,  1, 0, 8'h55, "R9 overscan line 240 outside");
        probe(100, 100,  0, 1, 8'h55, "R9 display off disables");
        beam(300, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pairs();
        t_even_only();
        t_latch_hold();
        t_wrap();
        t_priority();
        t_window();
        t_bounds();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule